// File: doc/BRIEF.md
# Chopper Autozero Timing Generator

This block produces every timing signal a chopper-stabilised measurement front end needs. One frame is a full chopper cycle made of two phases of equal length. Two switch-drive pairs are produced: one for the input modulator and one for the output demodulator. Each pair has one side per phase. A programmable deadtime keeps both sides of a pair low at the start of every phase, so the two sides never conduct together. A correlated-double-sampling (CDS) phase line toggles once per frame, which gives it twice the chopper period.

At the first cycle of each phase, the block raises a one-cycle phase trigger. The trigger starts a programmable settling wait. When the wait ends, the block issues a counted burst of conversion-start pulses to an external oversampling converter. The pulse high time and the low gap between pulses are both programmable. The number of pulses in a burst is the oversampling ratio.

All configuration inputs are captured into shadow registers only when the block is enabled and at each frame boundary. Changing a configuration input in the middle of a frame therefore never produces a partial phase. Clearing the enable stops the block and zeroes its outputs.

Top module: `chop_az_timer`

## Requirements
- R1: The modulator pair and the demodulator pair switch in the same cycles. Their period is two phase lengths (`cfg_half_i` clocks per phase; a value of 0 acts as 1).
- R2: `cds_o` is low for the first frame after enable and inverts only at frame boundaries, so its period is four phase lengths.
- R3: In phase 0, `mod_a_o` is high from phase-cycle index `cfg_dead_i` up to the end of the phase, and side B is low. Phase 1 mirrors this on side B. The two sides are never high together, and a deadtime at or above the phase length keeps both sides low.
- R4: `phase_trig_o` is high for exactly the first cycle (index 0) of each phase.
- R5: For an accepted trigger in cycle T, the first conversion pulse is high from cycle T+1+S, where S is the settling value. S = 0 gives no wait.
- R6: A burst contains N pulses (`cfg_osr_i`). Each pulse is high for H cycles (`cfg_hi_i`), with G low cycles (`cfg_gap_i`) between pulses. A value of 0 for N, H or G acts as 1.
- R7: A phase trigger that arrives while a settling wait or burst is still active is ignored.
- R8: Configuration inputs take effect only when the block is enabled or at a frame boundary. A new phase length written mid-frame first applies in the next frame.
- R9: A low `enable_i` forces every output low after one clock edge. The next enable restarts in phase 0 with `cds_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Runs the frame when high |
| cfg_half_i | input | 32 | Phase length in clocks |
| cfg_dead_i | input | 32 | Deadtime in clocks at the start of each phase |
| cfg_settle_i | input | 32 | Settling wait after a phase trigger |
| cfg_osr_i | input | 11 | Number of conversion pulses per burst |
| cfg_hi_i | input | 16 | Conversion pulse high time |
| cfg_gap_i | input | 16 | Low time between conversion pulses |
| mod_a_o | output | 1 | Modulator drive, phase 0 side |
| mod_b_o | output | 1 | Modulator drive, phase 1 side |
| dem_a_o | output | 1 | Demodulator drive, phase 0 side |
| dem_b_o | output | 1 | Demodulator drive, phase 1 side |
| cds_o | output | 1 | CDS phase line |
| phase_trig_o | output | 1 | One-cycle pulse at each phase start |
| conv_o | output | 1 | Conversion-start pulse train |

## Verification
Cycle 0 is defined as the cycle after the clock edge that first samples `enable_i` high. From that cycle, the drives, the CDS line and the phase trigger follow the phase counter with no added delay. For an accepted trigger in cycle T, the conversion pulses start at cycle T+1+S. A low enable clears every output on the next edge. The bench drives its inputs and samples the outputs on falling edges, and indexes each sample from the starting edge. A cycle-by-cycle model compares all seven outputs in every cycle of every table entry. Separate counts check the burst lengths, and directed runs cover mid-frame reconfiguration and disable during a burst.

// File: rtl/chop_pkg.sv
package chop_pkg;

    parameter int CNT_W = 32;
    parameter int OSR_W = 11;
    parameter int PW_W  = 16;

    typedef struct packed {
        logic [CNT_W-1:0] half;
        logic [CNT_W-1:0] dead;
        logic [CNT_W-1:0] settle;
        logic [OSR_W-1:0] osr;
        logic [PW_W-1:0]  hi;
        logic [PW_W-1:0]  gap;
    } chop_cfg_t;

    typedef enum logic [1:0] {
        BST_IDLE,
        BST_SETTLE,
        BST_HIGH,
        BST_GAP
    } burst_st_e;

    // Zero counts that would stall a counter are raised to one.
    function automatic chop_cfg_t cfg_sanitize(chop_cfg_t c);
        chop_cfg_t r;
        r = c;
        if (c.half == '0) r.half = CNT_W'(1);
        if (c.osr  == '0) r.osr  = OSR_W'(1);
        if (c.hi   == '0) r.hi   = PW_W'(1);
        if (c.gap  == '0) r.gap  = PW_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/chop_frame_timer.sv
module chop_frame_timer
    import chop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  chop_cfg_t        cfg_i,
    output logic             run_o,
    output logic             phase_o,
    output logic             cds_o,
    output logic             trig_o,
    output logic [CNT_W-1:0] pcnt_o,
    output chop_cfg_t        shadow_o
);

    logic             run_q;
    logic             phase_q;
    logic             cds_q;
    logic [CNT_W-1:0] pcnt_q;
    chop_cfg_t        shadow_q;
    logic             phase_last;
    logic             frame_last;

    assign phase_last = (pcnt_q == shadow_q.half - CNT_W'(1));
    assign frame_last = run_q && phase_q && phase_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            phase_q  <= 1'b0;
            cds_q    <= 1'b0;
            pcnt_q   <= '0;
            shadow_q <= cfg_sanitize('0);
        end else if (!enable_i) begin
            run_q   <= 1'b0;
            phase_q <= 1'b0;
            cds_q   <= 1'b0;
            pcnt_q  <= '0;
        end else if (!run_q) begin
            run_q    <= 1'b1;
            phase_q  <= 1'b0;
            cds_q    <= 1'b0;
            pcnt_q   <= '0;
            shadow_q <= cfg_sanitize(cfg_i);
        end else if (phase_last) begin
            pcnt_q  <= '0;
            phase_q <= ~phase_q;
            if (phase_q) begin
                cds_q    <= ~cds_q;
                shadow_q <= cfg_sanitize(cfg_i);
            end
        end else begin
            pcnt_q <= pcnt_q + CNT_W'(1);
        end
    end

    assign run_o    = run_q;
    assign phase_o  = phase_q;
    assign cds_o    = cds_q;
    assign pcnt_o   = pcnt_q;
    assign shadow_o = shadow_q;
    assign trig_o   = run_q && (pcnt_q == '0);

    AST_CDS_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
        (enable_i && run_q && !frame_last) |=> $stable(cds_q)); // R2

endmodule

// File: rtl/chop_switch_drive.sv
module chop_switch_drive
    import chop_pkg::*;
#(
    parameter int N_PAIRS = 2
)(
    input  logic               run_i,
    input  logic               phase_i,
    input  logic [CNT_W-1:0]   pcnt_i,
    input  logic [CNT_W-1:0]   dead_i,
    output logic [N_PAIRS-1:0] drv_a_o,
    output logic [N_PAIRS-1:0] drv_b_o
);

    logic open_w;

    // A side may conduct only once the deadtime of the current phase has passed.
    assign open_w = run_i && (pcnt_i >= dead_i);

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        assign drv_a_o[g] = open_w && !phase_i;
        assign drv_b_o[g] = open_w &&  phase_i;
    end

endmodule

// File: rtl/chop_conv_burst.sv
module chop_conv_burst
    import chop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             trig_i,
    input  chop_cfg_t        cfg_i,
    output logic             conv_o
);

    burst_st_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OSR_W-1:0] left_q;
    logic [PW_W-1:0]  hi_q;
    logic [PW_W-1:0]  gap_q;

    always_ff @(posedge clk) begin
        if (rst || !enable_i) begin
            st_q   <= BST_IDLE;
            cnt_q  <= '0;
            left_q <= '0;
            hi_q   <= PW_W'(1);
            gap_q  <= PW_W'(1);
        end else begin
            unique case (st_q)
                BST_IDLE: begin
                    if (trig_i) begin
                        hi_q   <= cfg_i.hi;
                        gap_q  <= cfg_i.gap;
                        left_q <= cfg_i.osr - OSR_W'(1);
                        if (cfg_i.settle == '0) begin
                            st_q  <= BST_HIGH;
                            cnt_q <= CNT_W'(cfg_i.hi) - CNT_W'(1);
                        end else begin
                            st_q  <= BST_SETTLE;
                            cnt_q <= cfg_i.settle - CNT_W'(1);
                        end
                    end
                end
                BST_SETTLE: begin
                    if (cnt_q == '0) begin
                        st_q  <= BST_HIGH;
                        cnt_q <= CNT_W'(hi_q) - CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                BST_HIGH: begin
                    if (cnt_q == '0) begin
                        if (left_q == '0) begin
                            st_q <= BST_IDLE;
                        end else begin
                            st_q  <= BST_GAP;
                            cnt_q <= CNT_W'(gap_q) - CNT_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                BST_GAP: begin
                    if (cnt_q == '0) begin
                        st_q   <= BST_HIGH;
                        cnt_q  <= CNT_W'(hi_q) - CNT_W'(1);
                        left_q <= left_q - OSR_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: st_q <= BST_IDLE;
            endcase
        end
    end

    assign conv_o = (st_q == BST_HIGH);

    AST_IDLE_NO_PENDING: assert property (@(posedge clk) disable iff (rst)
        (st_q == BST_IDLE) |-> (left_q == '0)); // R6

    AST_NO_GAP_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == BST_IDLE) |=> (st_q != BST_GAP)); // R5

endmodule

// File: rtl/chop_az_timer.sv
module chop_az_timer
    import chop_pkg::*;
#(
    parameter int N_PAIRS = 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] cfg_half_i,
    input  logic [CNT_W-1:0] cfg_dead_i,
    input  logic [CNT_W-1:0] cfg_settle_i,
    input  logic [OSR_W-1:0] cfg_osr_i,
    input  logic [PW_W-1:0]  cfg_hi_i,
    input  logic [PW_W-1:0]  cfg_gap_i,
    output logic             mod_a_o,
    output logic             mod_b_o,
    output logic             dem_a_o,
    output logic             dem_b_o,
    output logic             cds_o,
    output logic             phase_trig_o,
    output logic             conv_o
);

    localparam int MOD_IDX = 0;
    localparam int DEM_IDX = (N_PAIRS > 1) ? 1 : 0;

    chop_cfg_t          cfg_w;
    chop_cfg_t          shadow_w;
    logic               run_w;
    logic               phase_w;
    logic               trig_w;
    logic [CNT_W-1:0]   pcnt_w;
    logic [N_PAIRS-1:0] drv_a_w;
    logic [N_PAIRS-1:0] drv_b_w;

    assign cfg_w = '{half: cfg_half_i, dead: cfg_dead_i, settle: cfg_settle_i,
                     osr: cfg_osr_i, hi: cfg_hi_i, gap: cfg_gap_i};

    chop_frame_timer u_frame (
        .clk      (clk),
        .rst      (rst),
        .enable_i (enable_i),
        .cfg_i    (cfg_w),
        .run_o    (run_w),
        .phase_o  (phase_w),
        .cds_o    (cds_o),
        .trig_o   (trig_w),
        .pcnt_o   (pcnt_w),
        .shadow_o (shadow_w)
    );

    chop_switch_drive #(.N_PAIRS(N_PAIRS)) u_drive (
        .run_i   (run_w),
        .phase_i (phase_w),
        .pcnt_i  (pcnt_w),
        .dead_i  (shadow_w.dead),
        .drv_a_o (drv_a_w),
        .drv_b_o (drv_b_w)
    );

    chop_conv_burst u_burst (
        .clk      (clk),
        .rst      (rst),
        .enable_i (enable_i),
        .trig_i   (trig_w),
        .cfg_i    (shadow_w),
        .conv_o   (conv_o)
    );

    assign mod_a_o      = drv_a_w[MOD_IDX];
    assign mod_b_o      = drv_b_w[MOD_IDX];
    assign dem_a_o      = drv_a_w[DEM_IDX];
    assign dem_b_o      = drv_b_w[DEM_IDX];
    assign phase_trig_o = trig_w;

    AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mod_a_o && mod_b_o) && !(dem_a_o && dem_b_o)); // R3

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !(mod_a_o || mod_b_o || dem_a_o || dem_b_o ||
                        cds_o || phase_trig_o || conv_o)); // R9

endmodule

// File: tb/test_chop_az_timer.sv
module test_chop_az_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0;
    logic [31:0] cfg_half_i = '0;
    logic [31:0] cfg_dead_i = '0;
    logic [31:0] cfg_settle_i = '0;
    logic [10:0] cfg_osr_i = '0;
    logic [15:0] cfg_hi_i = '0;
    logic [15:0] cfg_gap_i = '0;
    logic mod_a_o, mod_b_o, dem_a_o, dem_b_o, cds_o, phase_trig_o, conv_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    chop_az_timer i_chop_az_timer (
        .clk(clk), .rst(rst), .enable_i(enable_i),
        .cfg_half_i(cfg_half_i), .cfg_dead_i(cfg_dead_i),
        .cfg_settle_i(cfg_settle_i), .cfg_osr_i(cfg_osr_i),
        .cfg_hi_i(cfg_hi_i), .cfg_gap_i(cfg_gap_i),
        .mod_a_o(mod_a_o), .mod_b_o(mod_b_o), .dem_a_o(dem_a_o),
        .dem_b_o(dem_b_o), .cds_o(cds_o), .phase_trig_o(phase_trig_o),
        .conv_o(conv_o)
    );

    // half, dead, settle, osr, hi, gap, expected conversion pulses over two frames
    localparam int TBL [5][7] = '{
        '{40,  3, 5, 3, 2, 1, 12},
        '{20,  0, 0, 4, 1, 1, 16},
        '{12,  2, 3, 4, 2, 2,  8},   // R7: burst outlasts a phase
        '{ 8,  0, 0, 0, 0, 0,  4},   // zero counts act as one
        '{16, 20, 2, 2, 3, 0,  8}    // deadtime beyond phase
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int outs();
        return {mod_a_o, mod_b_o, dem_a_o, dem_b_o, cds_o, phase_trig_o, conv_o};
    endfunction

    task automatic set_cfg(input int h, input int d, input int s, input int n,
                           input int p, input int g);
        cfg_half_i = 32'(h); cfg_dead_i = 32'(d); cfg_settle_i = 32'(s);
        cfg_osr_i = 11'(n); cfg_hi_i = 16'(p); cfg_gap_i = 16'(g);
    endtask

    // Starts a run: drives enable at a falling edge and returns just after the starting edge.
    task automatic start_run();
        @(negedge clk);
        enable_i = 1'b1;
        @(posedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable_i = 1'b0;
        @(posedge clk);
    endtask

    task automatic run_entry(input int idx);
        int h, d, s, n, p, g, busy_end, burst_t, rises;
        bit prev;
        h = TBL[idx][0]; d = TBL[idx][1]; s = TBL[idx][2];
        n = TBL[idx][3] == 0 ? 1 : TBL[idx][3];
        p = TBL[idx][4] == 0 ? 1 : TBL[idx][4];
        g = TBL[idx][5] == 0 ? 1 : TBL[idx][5];
        @(negedge clk);
        set_cfg(TBL[idx][0], d, s, TBL[idx][3], TBL[idx][4], TBL[idx][5]);
        start_run();
        busy_end = -1; burst_t = -1000; rises = 0; prev = 1'b0;
        for (int t = 0; t < 4 * h; t++) begin
            int pc, ph, cd, tr, da, db, cv, off, exp;
            @(negedge clk);
            pc = t % h; ph = (t / h) % 2; cd = (t / (2 * h)) % 2;
            tr = (pc == 0);
            da = (ph == 0 && pc >= d);
            db = (ph == 1 && pc >= d);
            cv = 0;
            if (t > burst_t && t <= busy_end) begin
                off = t - burst_t - 1 - s;
                cv = (off >= 0 && (off % (p + g)) < p);
            end
            if (tr != 0 && t > busy_end) begin
                burst_t = t;
                busy_end = t + s + (n - 1) * (p + g) + p;
            end
            exp = {da[0], db[0], da[0], db[0], cd[0], tr[0], cv[0]};
            chk(outs() == exp, "R1/R2/R3/R4/R5/R6", "output vector", outs(), exp);
            if (conv_o && !prev) rises++;
            prev = conv_o;
        end
        chk(rises == TBL[idx][6], "R6/R7", "pulses per two frames", rises, TBL[idx][6]);
        stop_run();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(outs() == 0, "R9", "reset state", outs(), 0);

        for (int i = 0; i < 5; i++) run_entry(i);

        // R8: phase length written mid-frame applies from the next frame
        @(negedge clk);
        set_cfg(10, 0, 0, 1, 1, 1);
        start_run();
        for (int t = 0; t < 36; t++) begin
            int et, ec;
            @(negedge clk);
            et = (t == 0 || t == 10 || t == 20 || t == 26 || t == 32);
            ec = (t >= 20 && t < 32);
            chk(phase_trig_o == et[0], "R8", "phase trigger", phase_trig_o, et);
            chk(cds_o == ec[0], "R8", "cds after reload", cds_o, ec);
            if (t == 3) cfg_half_i = 32'd6;
        end
        stop_run();

        // R9: disable during a burst, then restart
        @(negedge clk);
        set_cfg(40, 3, 5, 3, 2, 1);
        start_run();
        for (int t = 0; t < 7; t++) @(negedge clk);
        chk(conv_o == 1'b1, "R5", "burst active before disable", conv_o, 1);
        enable_i = 1'b0;
        @(negedge clk);
        chk(outs() == 0, "R9", "outputs after disable", outs(), 0);
        enable_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(phase_trig_o == 1'b1 && cds_o == 1'b0, "R9", "restart phase 0",
            {phase_trig_o, cds_o}, 2);
        chk(mod_a_o == 1'b0, "R3", "deadtime at restart", mod_a_o, 0);
        repeat (3) @(negedge clk);
        chk(mod_a_o == 1'b1 && dem_a_o == 1'b1, "R1", "drives after deadtime",
            {mod_a_o, dem_a_o}, 3);
        stop_run();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule